// File: doc/BRIEF.md
# Virtual output queue grouped priority list

This block holds the cells waiting at one switch input, sorted into one FIFO per output (virtual output queues). Each arriving cell names its destination output and carries an arrival timestamp. The timestamp is stored at the tail of that output's FIFO. Alongside the FIFOs the block keeps one ordered list of the non-empty queues. A queue's cells are never interleaved with another queue's cells in this list.

When a queue goes from empty to non-empty, it enters the list at the head. A cell that joins a queue which already holds cells leaves the list order alone. When a dequeue removes a queue's last cell, the queue leaves the list and every queue behind it moves up one place. For each queue, a matching scheduler sees the timestamp of the oldest cell. Since the oldest cell has the earliest timestamp, it has the highest priority toward its output.

The scheduler also sees an active flag for each queue. A queue counts as active only when it holds cells and its head cell is marked active. An inactive head cell therefore makes the whole queue inactive.

Top module: `voq_order_list`

## Requirements
- R1: After reset every queue is empty, `order_count` is 0, every `order` slot reads 0, `active` is 0 and `drop_count` is 0.
- R2: An accepted arrival to an empty queue places that queue's index in list position 0 (`order[IW-1:0]`). Every queue already listed moves one position toward the tail.
- R3: An accepted arrival to a non-empty queue leaves the order of the listed queues unchanged.
- R4: Each queue is first-in first-out. `head_ts[v*TS_W +: TS_W]` shows the timestamp of the oldest cell in non-empty queue v, and each dequeue exposes the next cell in arrival order.
- R5: A dequeue that removes the last cell of a queue takes that queue out of the list. The queues behind it each move up one position, and `order_count` drops by one.
- R6: An arrival to a queue that holds DEPTH cells at the start of the cycle is dropped and `drop_count` increments by one. The dropped arrival leaves the queue contents and the list unchanged.
- R7: A dequeue naming an empty queue has no effect.
- R8: An arrival and a dequeue to the same queue in the same cycle are both performed. If the dequeue took the queue's only cell, the queue ends at list position 0.
- R9: `active[v]` is 1 exactly when queue v holds at least one cell and `head_ok[v]` is 1. It follows `head_ok` in the same cycle.
- R10: The list holds at most N distinct queue indices. Position i sits at `order[i*IW +: IW]`, position 0 is the head, and positions at or beyond `order_count` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_dest | input | IW | Destination output of the arriving cell |
| arr_ts | input | TS_W | Arrival timestamp of the arriving cell |
| deq_valid | input | 1 | Remove the head cell of one queue |
| deq_dest | input | IW | Queue to dequeue from |
| head_ok | input | N | Per-queue flag marking the head cell active this phase |
| head_ts | output | N*TS_W | Head timestamp of each queue |
| order | output | N*IW | Ordered list of non-empty queue indices, head in the lowest field |
| order_count | output | LW | Number of listed queues |
| active | output | N | Per-queue active flag |
| drop_count | output | DW | Arrivals dropped because their queue was full |

## Verification
The bench targets a queue that empties and refills in the same cycle. A design that applied the removal after the insertion would leave that queue at its old position, or would lose it from the list altogether. It also removes queues from the middle and from the tail of the list. A wrong shift there would duplicate one entry, or leave a stale index in a slot past the count. Arrivals to a full queue are a third target: a design that wrote the dropped cell anyway would corrupt the FIFO order that later dequeues expose.

// File: rtl/voq_order_list.sv
module voq_order_list #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int TS_W  = 8,
  parameter int DW    = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int LW   = $clog2(N + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arr_valid,
  input  logic [IW-1:0]   arr_dest,
  input  logic [TS_W-1:0] arr_ts,
  input  logic            deq_valid,
  input  logic [IW-1:0]   deq_dest,
  input  logic [N-1:0]    head_ok,
  output logic [N*TS_W-1:0] head_ts,
  output logic [N*IW-1:0] order,
  output logic [LW-1:0]   order_count,
  output logic [N-1:0]    active,
  output logic [DW-1:0]   drop_count
);

  logic [TS_W-1:0] mem [N][DEPTH];
  logic [PW-1:0]   rd_p [N];
  logic [PW-1:0]   wr_p [N];
  logic [CW-1:0]   cnt [N];
  logic [IW-1:0]   ord [N];
  logic [IW-1:0]   tmp [N];
  logic [IW-1:0]   nord [N];
  logic [LW-1:0]   len, tlen, nlen;
  logic [IW-1:0]   rpos;
  logic            rhit;
  logic [N-1:0]    full_q, nonempty;

  function automatic logic [PW-1:0] nextp(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar v = 0; v < N; v++) begin : g_q
    assign full_q[v]   = (cnt[v] == CW'(DEPTH));
    assign nonempty[v] = (cnt[v] != '0);
    assign head_ts[v*TS_W +: TS_W] = mem[v][rd_p[v]];
    assign order[v*IW +: IW] = ord[v];
  end

  assign active      = nonempty & head_ok;
  assign order_count = len;

  wire acc = arr_valid && !full_q[arr_dest];
  wire dok = deq_valid && nonempty[deq_dest];
  wire emp = dok && (cnt[deq_dest] == CW'(1));
  wire ins = acc && (!nonempty[arr_dest] || (emp && deq_dest == arr_dest));

  always_comb begin
    rpos = '0;
    rhit = 1'b0;
    for (int i = 0; i < N; i++)
      if (!rhit && LW'(i) < len && ord[i] == deq_dest) begin
        rpos = IW'(i);
        rhit = 1'b1;
      end
    tmp  = ord;
    tlen = len;
    if (emp) begin
      for (int i = 0; i < N - 1; i++)
        if (IW'(i) >= rpos) tmp[i] = ord[i+1];
      tmp[N-1] = '0;
      tlen = len - 1'b1;
    end
    nord = tmp;
    nlen = tlen;
    if (ins) begin
      nord[0] = arr_dest;
      for (int i = 1; i < N; i++) nord[i] = tmp[i-1];
      nlen = tlen + 1'b1;
    end
  end

  always_ff @(posedge clk)
    for (int v = 0; v < N; v++)
      if (acc && arr_dest == IW'(v)) mem[v][wr_p[v]] <= arr_ts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < N; v++) begin
        cnt[v]  <= '0;
        rd_p[v] <= '0;
        wr_p[v] <= '0;
        ord[v]  <= '0;
      end
      len        <= '0;
      drop_count <= '0;
    end else begin
      for (int v = 0; v < N; v++) begin
        if (acc && arr_dest == IW'(v)) wr_p[v] <= nextp(wr_p[v]);
        if (dok && deq_dest == IW'(v)) rd_p[v] <= nextp(rd_p[v]);
        cnt[v] <= cnt[v] + CW'(acc && arr_dest == IW'(v)) - CW'(dok && deq_dest == IW'(v));
        ord[v] <= nord[v];
      end
      len <= nlen;
      if (arr_valid && !acc) drop_count <= drop_count + 1'b1;
    end
  end

endmodule

// File: rtl/voq_order_list_chk.sv
module voq_order_list_chk #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int LW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arr_valid,
  input logic [IW-1:0] arr_dest,
  input logic          deq_valid,
  input logic [IW-1:0] deq_dest,
  input logic [N*IW-1:0] order,
  input logic [LW-1:0] order_count,
  input logic [N-1:0]  active,
  input logic [DW-1:0] drop_count,
  input logic [N-1:0]  full_q,
  input logic [N-1:0]  nonempty
);

  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    order_count <= LW'(N));

  assert_head_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !nonempty[arr_dest] |=> order[IW-1:0] == $past(arr_dest) && order_count != '0);

  assert_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && full_q[arr_dest] |=> drop_count == $past(drop_count) + 1'b1);

  assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && full_q[arr_dest] && !deq_valid |=> $stable(order) && $stable(order_count));

  assert_empty_deq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && !nonempty[deq_dest] && !arr_valid |=> $stable(order) && $stable(order_count));

  assert_shrink_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_valid |=> order_count >= $past(order_count));

  assert_active_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) <= int'(order_count));

endmodule

bind voq_order_list voq_order_list_chk #(.N(N), .IW(IW), .LW(LW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dest(arr_dest),
  .deq_valid(deq_valid), .deq_dest(deq_dest), .order(order),
  .order_count(order_count), .active(active), .drop_count(drop_count),
  .full_q(full_q), .nonempty(nonempty)
);

// File: tb/voq_order_list_tb.sv
`timescale 1ns/1ps
module voq_order_list_tb;
  localparam int N = 4, DEPTH = 4, TS_W = 8, DW = 16;
  localparam int IW = 2, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arr_valid = 1'b0, deq_valid = 1'b0;
  logic [IW-1:0] arr_dest = '0, deq_dest = '0;
  logic [TS_W-1:0] arr_ts = '0;
  logic [N-1:0] head_ok = '1;
  logic [N*TS_W-1:0] head_ts;
  logic [N*IW-1:0] order;
  logic [LW-1:0] order_count;
  logic [N-1:0] active;
  logic [DW-1:0] drop_count;

  voq_order_list #(.N(N), .DEPTH(DEPTH), .TS_W(TS_W), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dest(arr_dest),
    .arr_ts(arr_ts), .deq_valid(deq_valid), .deq_dest(deq_dest),
    .head_ok(head_ok), .head_ts(head_ts), .order(order),
    .order_count(order_count), .active(active), .drop_count(drop_count));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int mts[N][DEPTH];
  int mcnt[N];
  int mlist[N];
  int mlen = 0, mdrop = 0, tsc = 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_step(bit av, int ad, int ats, bit dv, int dd);
    bit acc, dok, emp, was_empty;
    int p;
    acc = av && mcnt[ad] < DEPTH;
    if (av && !acc) mdrop++;
    dok = dv && mcnt[dd] > 0;
    emp = dok && mcnt[dd] == 1;
    was_empty = (mcnt[ad] == 0);
    if (dok) begin
      for (int k = 0; k < DEPTH - 1; k++) mts[dd][k] = mts[dd][k+1];
      mcnt[dd]--;
    end
    if (emp) begin
      p = 0;
      for (int k = 0; k < mlen; k++) if (mlist[k] == dd) p = k;
      for (int k = p; k < N - 1; k++) mlist[k] = mlist[k+1];
      mlist[N-1] = 0;
      mlen--;
    end
    if (acc) begin
      mts[ad][mcnt[ad]] = ats;
      mcnt[ad]++;
      if (was_empty || (emp && dd == ad)) begin
        for (int k = N - 1; k > 0; k--) mlist[k] = mlist[k-1];
        mlist[0] = ad;
        mlen++;
      end
    end
  endfunction

  task automatic compare_all(string tag);
    chk({tag, " R5 list length"}, int'(order_count), mlen);
    for (int i = 0; i < N; i++)
      chk({tag, " R10 R2 R3 list slot"}, int'(order[i*IW +: IW]), (i < mlen) ? mlist[i] : 0);
    chk({tag, " R6 drop count"}, int'(drop_count), mdrop);
    for (int v = 0; v < N; v++) begin
      chk({tag, " R9 active"}, int'(active[v]), int'(mcnt[v] > 0 && head_ok[v]));
      if (mcnt[v] > 0) chk({tag, " R4 head ts"}, int'(head_ts[v*TS_W +: TS_W]), mts[v][0]);
    end
  endtask

  task automatic step(string tag, bit av, int ad, bit dv, int dd, logic [N-1:0] hok);
    @(negedge clk);
    arr_valid = av; arr_dest = IW'(ad); arr_ts = TS_W'(tsc);
    deq_valid = dv; deq_dest = IW'(dd); head_ok = hok;
    model_step(av, ad, tsc & 8'hff, dv, dd);
    if (av) tsc++;
    @(posedge clk);
    #2;
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int v = 0; v < N; v++) begin mcnt[v] = 0; mlist[v] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset count", int'(order_count), 0);
    chk("R1 reset order", int'(order), 0);
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset drops", int'(drop_count), 0);

    step("R2 first", 1, 2, 0, 0, '1);
    chk("R2 head is 2", int'(order[IW-1:0]), 2);
    step("R2 second", 1, 0, 0, 0, '1);
    chk("R2 head is 0", int'(order[IW-1:0]), 0);
    step("R3 append", 1, 2, 0, 0, '1);
    step("R2 third", 1, 1, 0, 0, '1);
    step("R5 middle removal", 0, 0, 1, 0, '1);
    step("R7 empty deq", 0, 0, 1, 3, '1);
    step("R4 pop 2", 0, 0, 1, 2, '1);
    for (int k = 0; k < 4; k++) step("R6 fill", 1, 1, 0, 0, '1);
    step("R6 full drop", 1, 1, 0, 0, '1);
    step("R6 full drop with deq", 1, 1, 1, 1, '1);
    step("R8 refill same cycle", 1, 2, 1, 2, '1);
    chk("R8 head is 2", int'(order[IW-1:0]), 2);
    step("R9 head inactive", 0, 0, 0, 0, 4'b0101);

    for (int c = 0; c < 3000; c++)
      step("random", ($urandom % 10) < 6, $urandom % N, ($urandom % 2) == 1,
           $urandom % N, N'($urandom));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule